// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Controller

This block is the control core of a FIFO whose producer and consumer run on separate clocks. It owns the write and read pointers, the storage array, a registered data output, and two status pins whose meaning depends on a mode chosen during master reset. In standard mode the write-side pin is an active-low full flag and the read-side pin is an active-low empty flag. A word is fetched only when a read is requested.

In fall-through mode the write-side pin becomes an active-high "no room" indicator. The read-side pin becomes an active-low "word valid" indicator. The oldest stored word moves into the output register by itself, and a read only retires the word already on display. In this mode the output register counts as one more storage slot.

Pointers cross between the clock domains in Gray code through synchroniser chains. Either reset input returns the pointers and flags to the empty state. Only master reset samples the mode input.

Top module: `dcfifo_ctl`

## Requirements
- R1: Standard mode (mode input low while master reset is low): after exactly DEPTH writes with no reads, the write status pin is 0. After DEPTH-1 such writes it is 1. A write while full stores nothing and moves no pointer.
- R2: Fall-through mode (mode input high while master reset is low): the write status pin is 0 while space remains. It reaches 1 only after DEPTH+1 writes with no reads, and writes beyond that are ignored.
- R3: Standard mode: the read status pin is 0 while the FIFO is empty. A read request while empty leaves the data output and the read pointer unchanged.
- R4: Standard mode: an accepted read places the next word, in write order, on the data output at the read-clock edge that accepts it.
- R5: Fall-through mode: the first word written into an empty FIFO appears on the data output with the read status pin at 0, without any read request.
- R6: Fall-through mode: a read with the read status pin at 0 retires the displayed word, and the next word follows. When the last word is retired, the pin returns to 1 and the data output keeps the retired word. A read while the pin is 1 is ignored.
- R7: The mode is taken from the mode input only while master reset is low. Changing the mode input at any other time has no effect.
- R8: A partial reset empties the FIFO and clears both flags to their empty-state values, and it keeps the current mode.
- R9: Status pins settle within a small fixed number of edges. The write pin follows a write within two write-clock edges. The read pin follows a write within five read-clock edges when the two clocks run at the same rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low; samples the mode input |
| prs_n | input | 1 | Partial reset, active low; keeps the mode |
| fwft_sel | input | 1 | Mode input: 0 standard, 1 fall-through |
| wen_n | input | 1 | Write enable, active low |
| wdata | input | WIDTH | Write data |
| ren_n | input | 1 | Read enable, active low |
| rdata | output | WIDTH | Registered read data |
| wr_stat_n | output | 1 | Full (standard, active low) or no-room (fall-through, active high) |
| rd_stat_n | output | 1 | Empty (standard, active low) or word-valid (fall-through, active low) |

## Verification
On every cycle the assertions check four things: a full FIFO holds its write pointer, an empty one holds its read pointer, the fall-through stage loads as soon as stored data exists, and retiring the last word drops the valid indicator while the data stays put. Mode stability outside master reset is also checked on every cycle. The exact write counts at which the status pins flip, the order of the returned data, and that a mode change after reset has no effect can only be shown by the bench's scenarios. The same holds for the empty state after a partial reset, because these involve counting stimulus against a model.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a Gray-coded pointer.
module dcfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stage_d;
        if (i == 0) begin : g_first
            assign stage_d = d;
        end else begin : g_rest
            assign stage_d = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) stage_q[i] <= '0;
            else         stage_q[i] <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
// Write-domain pointer, full detection and write status pin.
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          arst_n,
    input  logic          mrs_n,
    input  logic          fwft_sel,
    input  logic          wen_n,
    input  logic [AW:0]   rgray_sync,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW:0]   wgray,
    output logic          wr_stat_n
);
    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        full;
        logic        full_pin;
    } wr_state_t;

    wr_state_t  s_d, s_q;
    fifo_mode_e mode_q;
    logic       we_c;

    // Mode is sampled only while master reset is held.
    always_ff @(posedge wclk) begin
        if (!mrs_n) mode_q <= fifo_mode_e'(fwft_sel);
    end

    always_comb begin
        s_d        = s_q;
        we_c       = !wen_n && !s_q.full;
        s_d.bin    = s_q.bin + (AW+1)'(we_c);
        s_d.gray   = s_d.bin ^ (s_d.bin >> 1);
        s_d.full   = (s_d.gray == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
        s_d.full_pin = s_q.full;
    end

    always_ff @(posedge wclk or negedge arst_n) begin
        if (!arst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign we        = we_c;
    assign waddr     = s_q.bin[AW-1:0];
    assign wgray     = s_q.gray;
    assign wr_stat_n = (mode_q == MODE_FWFT) ? s_q.full_pin : ~s_q.full_pin;

    assert_full_blocks_write_R1: assert property (@(posedge wclk) disable iff (!arst_n)
        (s_q.full && !wen_n) |=> $stable(s_q.bin));

    assert_full_rise_needs_write_R2: assert property (@(posedge wclk) disable iff (!arst_n)
        $rose(s_q.full) |-> $past(!wen_n));

    assert_mode_held_R7: assert property (@(posedge wclk) disable iff (!mrs_n)
        mrs_n |=> $stable(mode_q));
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
// Read-domain pointer, empty detection, output register and read status pin.
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW    = 4,
    parameter int WIDTH = 36
) (
    input  logic             rclk,
    input  logic             arst_n,
    input  logic             mrs_n,
    input  logic             fwft_sel,
    input  logic             ren_n,
    input  logic [AW:0]      wgray_sync,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rgray,
    output logic [WIDTH-1:0] rdata,
    output logic             rd_stat_n
);
    typedef struct packed {
        logic [AW:0]      bin;
        logic [AW:0]      gray;
        logic             empty;
        logic             empty_pin;
        logic             ov;
        logic [WIDTH-1:0] dout;
    } rd_state_t;

    localparam rd_state_t RST = '{bin: '0, gray: '0, empty: 1'b1,
                                  empty_pin: 1'b1, ov: 1'b0, dout: '0};

    rd_state_t  s_d, s_q;
    fifo_mode_e mode_q;
    logic       fwft, pop_out, load, std_take, take;

    always_ff @(posedge rclk) begin
        if (!mrs_n) mode_q <= fifo_mode_e'(fwft_sel);
    end

    always_comb begin
        s_d      = s_q;
        fwft     = (mode_q == MODE_FWFT);
        pop_out  = fwft && !ren_n && s_q.ov;
        load     = fwft && !s_q.empty && (!s_q.ov || pop_out);
        std_take = !fwft && !ren_n && !s_q.empty;
        take     = load || std_take;
        s_d.bin  = s_q.bin + (AW+1)'(take);
        s_d.gray = s_d.bin ^ (s_d.bin >> 1);
        s_d.empty     = (s_d.gray == wgray_sync);
        s_d.empty_pin = s_q.empty;
        s_d.ov   = fwft && (load || (s_q.ov && !pop_out));
        if (take) s_d.dout = mem_rdata;
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) s_q <= RST;
        else         s_q <= s_d;
    end

    assign raddr     = s_q.bin[AW-1:0];
    assign rgray     = s_q.gray;
    assign rdata     = s_q.dout;
    assign rd_stat_n = fwft ? ~s_q.ov : ~s_q.empty_pin;

    assert_empty_holds_ptr_R3: assert property (@(posedge rclk) disable iff (!arst_n)
        s_q.empty |=> $stable(s_q.bin));

    assert_fall_through_R5: assert property (@(posedge rclk) disable iff (!arst_n)
        (fwft && !s_q.ov && !s_q.empty) |=> s_q.ov);

    assert_last_read_keeps_data_R6: assert property (@(posedge rclk) disable iff (!arst_n)
        (fwft && s_q.ov && !ren_n && s_q.empty) |=> (!s_q.ov && $stable(s_q.dout)));
endmodule

// File: rtl/dcfifo_ctl.sv
`timescale 1ns/1ps
// Top: storage array plus write and read controllers joined by synchronisers.
module dcfifo_ctl #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 36,
    parameter int SYNC_STG = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrs_n,
    input  logic             prs_n,
    input  logic             fwft_sel,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] wdata,
    input  logic             ren_n,
    output logic [WIDTH-1:0] rdata,
    output logic             wr_stat_n,
    output logic             rd_stat_n
);
    localparam int AW = $clog2(DEPTH);

    logic             arst_n;
    logic [AW-1:0]    waddr, raddr;
    logic             we;
    logic [AW:0]      wgray, rgray, wgray_sync, rgray_sync;
    logic [WIDTH-1:0] mem [DEPTH];

    assign arst_n = mrs_n & prs_n;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    dcfifo_wr_ctl #(.AW(AW)) u_wr (
        .wclk      (wclk),
        .arst_n    (arst_n),
        .mrs_n     (mrs_n),
        .fwft_sel  (fwft_sel),
        .wen_n     (wen_n),
        .rgray_sync(rgray_sync),
        .waddr     (waddr),
        .we        (we),
        .wgray     (wgray),
        .wr_stat_n (wr_stat_n)
    );

    dcfifo_sync #(.W(AW+1), .STAGES(SYNC_STG)) u_r2w (
        .clk(wclk), .arst_n(arst_n), .d(rgray), .q(rgray_sync)
    );

    dcfifo_sync #(.W(AW+1), .STAGES(SYNC_STG)) u_w2r (
        .clk(rclk), .arst_n(arst_n), .d(wgray), .q(wgray_sync)
    );

    dcfifo_rd_ctl #(.AW(AW), .WIDTH(WIDTH)) u_rd (
        .rclk      (rclk),
        .arst_n    (arst_n),
        .mrs_n     (mrs_n),
        .fwft_sel  (fwft_sel),
        .ren_n     (ren_n),
        .wgray_sync(wgray_sync),
        .mem_rdata (mem[raddr]),
        .raddr     (raddr),
        .rgray     (rgray),
        .rdata     (rdata),
        .rd_stat_n (rd_stat_n)
    );
endmodule

// File: tb/tb_dcfifo_ctl.sv
`timescale 1ns/1ps
module tb_dcfifo_ctl;
    localparam int DEPTH = 8;
    localparam int WIDTH = 16;

    logic clk = 1'b0;
    logic mrs_n = 1'b0, prs_n = 1'b1, fwft_sel = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1;
    logic [WIDTH-1:0] wdata = '0;
    logic [WIDTH-1:0] rdata;
    logic wr_stat_n, rd_stat_n;

    int checks = 0, fails = 0;
    int q[$];
    int cap = DEPTH;
    int last_out = 0;
    bit fw_model = 1'b0;

    always #2 clk = ~clk;

    dcfifo_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .wclk(clk), .rclk(clk), .mrs_n(mrs_n), .prs_n(prs_n),
        .fwft_sel(fwft_sel), .wen_n(wen_n), .wdata(wdata), .ren_n(ren_n),
        .rdata(rdata), .wr_stat_n(wr_stat_n), .rd_stat_n(rd_stat_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int v);
        @(negedge clk);
        wen_n = 1'b0;
        wdata = WIDTH'(v);
        @(posedge clk);
        #1;
        if (q.size() < cap) q.push_back(v & 16'hFFFF);
        @(negedge clk);
        wen_n = 1'b1;
    endtask

    // Standard-mode read: data checked one half cycle after the accepting edge.
    task automatic rd_std(input string req);
        int exp;
        @(negedge clk);
        ren_n = 1'b0;
        @(posedge clk);
        #1;
        if (q.size() > 0) exp = q.pop_front();
        else              exp = last_out;
        last_out = exp;
        @(negedge clk);
        ren_n = 1'b1;
        chk(int'(rdata) == exp, req, int'(rdata), exp);
    endtask

    // Fall-through read: displayed word checked before it is retired.
    task automatic rd_ff(input string req);
        @(negedge clk);
        if (q.size() > 0) begin
            chk(rd_stat_n == 1'b0 && int'(rdata) == q[0], req, int'(rdata), q[0]);
        end
        ren_n = 1'b0;
        @(posedge clk);
        #1;
        if (q.size() > 0) last_out = q.pop_front();
        @(negedge clk);
        ren_n = 1'b1;
    endtask

    task automatic master_reset(input bit fw);
        @(negedge clk);
        mrs_n = 1'b0;
        fwft_sel = fw;
        idle(3);
        mrs_n = 1'b1;
        q.delete();
        fw_model = fw;
        cap = fw ? DEPTH + 1 : DEPTH;
        last_out = 0;
    endtask

    // Every cycle in fall-through mode: a valid indicator means the model's head is shown.
    always @(negedge clk) begin
        if (fw_model && mrs_n && prs_n && rd_stat_n == 1'b0) begin
            chk(q.size() > 0 && int'(rdata) == (q.size() > 0 ? q[0] : -1),
                "R5/R6 monitor", int'(rdata), q.size() > 0 ? q[0] : -1);
        end
    end

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // ---------------- standard mode ----------------
        master_reset(1'b0);
        idle(1);
        chk(wr_stat_n == 1'b1, "R1 reset not full", wr_stat_n, 1);
        chk(rd_stat_n == 1'b0, "R3 reset empty", rd_stat_n, 0);

        for (int i = 0; i < DEPTH - 1; i++) wr(16'h0A00 + i);
        idle(3);
        chk(wr_stat_n == 1'b1, "R1 one slot left", wr_stat_n, 1);
        wr(16'h0A00 + DEPTH - 1);
        idle(3);
        chk(wr_stat_n == 1'b0, "R1 full after DEPTH writes", wr_stat_n, 0);
        chk(rd_stat_n == 1'b1, "R9 not empty", rd_stat_n, 1);
        wr(16'h0BAD);   // ignored: FIFO full
        idle(3);

        for (int i = 0; i < DEPTH; i++) rd_std("R4 order");
        idle(6);
        chk(rd_stat_n == 1'b0, "R3 empty after draining", rd_stat_n, 0);
        chk(wr_stat_n == 1'b1, "R1 full cleared", wr_stat_n, 1);

        rd_std("R3 read while empty ignored");
        wr(16'h0055);
        idle(8);
        rd_std("R3 pointer unmoved");

        // R7: mode input changed outside master reset
        fwft_sel = 1'b1;
        wr(16'h0066);
        idle(8);
        chk(int'(rdata) == 16'h0055, "R7 no fall-through", int'(rdata), 16'h0055);
        chk(rd_stat_n == 1'b1, "R7 still empty-flag meaning", rd_stat_n, 1);
        rd_std("R7 standard read");

        // ---------------- fall-through mode ----------------
        master_reset(1'b1);
        idle(1);
        chk(wr_stat_n == 1'b0, "R2 reset room", wr_stat_n, 0);
        chk(rd_stat_n == 1'b1, "R5 reset no word", rd_stat_n, 1);

        wr(16'h0100);
        idle(8);
        chk(rd_stat_n == 1'b0 && int'(rdata) == 16'h0100, "R5 first word falls through",
            int'(rdata), 16'h0100);
        for (int i = 1; i < DEPTH; i++) wr(16'h0100 + i);
        idle(4);
        chk(wr_stat_n == 1'b0, "R2 room after DEPTH writes", wr_stat_n, 0);
        wr(16'h0100 + DEPTH);
        idle(4);
        chk(wr_stat_n == 1'b1, "R2 no room after DEPTH+1", wr_stat_n, 1);
        wr(16'h0EEE);   // ignored
        idle(4);

        for (int i = 0; i <= DEPTH; i++) rd_ff("R6 order");
        idle(4);
        chk(rd_stat_n == 1'b1, "R6 valid drops after last", rd_stat_n, 1);
        chk(int'(rdata) == 16'h0100 + DEPTH, "R6 data held", int'(rdata), 16'h0100 + DEPTH);
        rd_ff("R6 read while invalid");
        idle(2);
        chk(int'(rdata) == 16'h0100 + DEPTH, "R6 ignored read", int'(rdata), 16'h0100 + DEPTH);
        idle(4);
        chk(wr_stat_n == 1'b0, "R2 room returns", wr_stat_n, 0);

        // ---------------- partial reset ----------------
        wr(16'h0301); wr(16'h0302); wr(16'h0303);
        idle(8);
        @(negedge clk);
        prs_n = 1'b0;
        fwft_sel = 1'b0;
        q.delete();
        idle(3);
        prs_n = 1'b1;
        idle(1);
        chk(rd_stat_n == 1'b1, "R8 emptied", rd_stat_n, 1);
        chk(wr_stat_n == 1'b0, "R8 room", wr_stat_n, 0);
        wr(16'h0077);
        idle(8);
        chk(rd_stat_n == 1'b0 && int'(rdata) == 16'h0077, "R8 mode kept", int'(rdata), 16'h0077);
        rd_ff("R8 read after partial reset");
        idle(4);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule